// File: doc/BRIEF.md
# Flash Program and Erase Status Engine

This block stands in for the self-timed write machinery of a byte-wide flash memory. A command decoder hands it one request at a time: program one byte, erase one block, or erase the whole array. The block then stays busy for a fixed, parameterised number of clock cycles. While it is busy, any read returns a status byte instead of array contents. When the timed window ends, the block applies the result to a small register-file model of the array.

The status byte follows the usual polling scheme for flash. Bit 7 is the complement of the data's top bit while a program runs, and it is 0 while an erase runs. Bit 6 flips on every status read. Programming can only clear bits. Only erasing sets bits back to 1. A boot-lock input, captured when a request is accepted, shields one block from all three operations.

Requests arrive on a valid/ready channel. `req_ready` is high only while the engine is idle. A request offered while the engine is busy is not taken. A requester that keeps `req_valid` high is served once the engine becomes idle. A requester that drops `req_valid` earlier has its request discarded with no effect. Reads are a plain enable with one cycle of latency and no back-pressure.

Top module: `fpe_engine`

## Requirements
- R1: After reset every array byte reads FFh, `busy` is 0 and `req_ready` is 1.
- R2: A program request (op 0) stores the old byte ANDed with `req_data` at `req_addr`. Bits already at 0 stay 0 even when the new data has them at 1.
- R3: A block erase request (op 1) sets every byte of one block to FFh and leaves the other blocks unchanged. The block is selected by the top BLK_W bits of `req_addr`.
- R4: A chip erase request (op 2) sets every byte of the array to FFh.
- R5: If `boot_lock` is 1 in the cycle a request is accepted, that operation leaves the boot block (block index BOOT_BLK) unchanged. This holds for program, block erase and chip erase alike.
- R6: `busy` rises in the cycle after a request is accepted. It stays high for exactly PROG_CYC cycles for a program and exactly ERASE_CYC cycles for either erase.
- R7: `req_ready` is 0 whenever `busy` is 1. A request offered in that time and withdrawn before the engine becomes idle has no effect.
- R8: A read during a running operation returns a status byte. Bit 7 is the inverse of bit 7 of the data being programmed, or 0 during an erase. Bits 5 to 0 are 0.
- R9: Bit 6 of the status byte is 1 on the first status read of an operation. It then inverts on each further status read.
- R10: A read issued in the last busy cycle returns the array data as updated by the finishing operation, not status.
- R11: `rd_valid` and `rd_data` answer a read in the cycle after `rd_en` is high.
- R12: Op code 3 is accepted but does nothing: `busy` stays 0 and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_op | input | 2 | 0 program, 1 block erase, 2 chip erase, 3 none |
| req_addr | input | ADDR_W | Byte address; its top BLK_W bits select the block |
| req_data | input | 8 | Byte to program |
| boot_lock | input | 1 | Protect the boot block, captured at acceptance |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read answer present |
| rd_data | output | 8 | Array byte or status byte |
| busy | output | 1 | Operation in progress |

## Verification
An accepted request raises `busy` one edge later. The array result becomes visible PROG_CYC or ERASE_CYC edges after acceptance. A read's answer is due one edge after its strobe. The bench drives inputs and samples outputs 1 ns after each rising edge, so a read's result is taken one step after it is issued. It counts busy cycles by stepping once per edge until `busy` falls. The toggle and completion checks issue back-to-back reads starting in the first busy cycle. This puts the fourth read of a program exactly on the completion cycle.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_BLK  = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  localparam logic [7:0] ERASED = 8'hFF;

  // new value of one stored byte when an operation finishes
  function automatic logic [7:0] fpe_next(
    input op_e        op,
    input logic       addr_hit,
    input logic       blk_hit,
    input logic       guarded,
    input logic [7:0] old,
    input logic [7:0] wdat
  );
    logic [7:0] res;
    res = old;
    if (!guarded) begin
      case (op)
        OP_PROG: if (addr_hit) res = old & wdat;
        OP_BLK:  if (blk_hit) res = ERASED;
        OP_CHIP: res = ERASED;
        default: res = old;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/fpe_timer.sv
module fpe_timer #(
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_erase,
  output logic busy,
  output logic done
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PLOAD = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] ELOAD = CW'(ERASE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= start_erase ? ELOAD : PLOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);
endmodule

// File: rtl/fpe_array.sv
module fpe_array
  import fpe_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BLK_W    = 2,
  parameter int BOOT_BLK = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  op_e               op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic              op_lock,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_word
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SHIFT = ADDR_W - BLK_W;

  logic [DEPTH-1:0][7:0] mem;
  logic [DEPTH-1:0][7:0] nv;
  logic [BLK_W-1:0]      op_blk;

  assign op_blk = op_addr[ADDR_W-1 -: BLK_W];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [BLK_W-1:0] EBLK = BLK_W'(g >> SHIFT);
    localparam logic             BOOT = (int'(EBLK) == BOOT_BLK);
    assign nv[g] = fpe_next(op,
                            op_addr == ADDR_W'(g),
                            op_blk == EBLK,
                            op_lock && BOOT,
                            mem[g], op_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mem <= {DEPTH{ERASED}};
    else if (commit) mem <= nv;
  end

  // completing operation is visible to a read in its last cycle
  assign rd_word = commit ? nv[rd_addr] : mem[rd_addr];
endmodule

// File: rtl/fpe_status.sv
module fpe_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_status,
  input  logic       rd_fire,
  input  logic       is_prog,
  input  logic       data_msb,
  output logic [7:0] status
);
  logic tog;

  always_ff @(posedge clk) begin
    if (!rst_n) tog <= 1'b0;
    else if (start) tog <= 1'b0;
    else if (rd_fire && in_status) tog <= ~tog;
  end

  assign status = {is_prog ? ~data_msb : 1'b0, ~tog, 6'b0};
endmodule

// File: rtl/fpe_engine.sv
module fpe_engine
  import fpe_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 2,
  parameter int BOOT_BLK  = 0,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              boot_lock,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              busy
);
  op_e               cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        cur_data;
  logic              cur_lock;
  logic              accept, start, done, in_status;
  logic [7:0]        arr_word, stat_word;
  op_e               new_op;

  assign new_op    = op_e'(req_op);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign start     = accept && (new_op != OP_NONE);
  assign in_status = busy && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_op   <= OP_NONE;
      cur_addr <= '0;
      cur_data <= '0;
      cur_lock <= 1'b0;
    end else if (start) begin
      cur_op   <= new_op;
      cur_addr <= req_addr;
      cur_data <= req_data;
      cur_lock <= boot_lock;
    end
  end

  fpe_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_erase(new_op != OP_PROG), .busy(busy), .done(done)
  );

  fpe_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BOOT_BLK(BOOT_BLK)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(done), .op(cur_op),
    .op_addr(cur_addr), .op_data(cur_data), .op_lock(cur_lock),
    .rd_addr(rd_addr), .rd_word(arr_word)
  );

  fpe_status u_status (
    .clk(clk), .rst_n(rst_n), .start(start), .in_status(in_status),
    .rd_fire(rd_en), .is_prog(cur_op == OP_PROG), .data_msb(cur_data[7]),
    .status(stat_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= in_status ? stat_word : arr_word;
    end
  end
endmodule

// File: rtl/fpe_engine_chk.sv
module fpe_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rd_en,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       busy
);
  p_busy_blocks_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_busy_from_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  p_status_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && rd_valid) |-> (rd_data[5:0] == 6'b0));

  p_toggle_flips_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(busy, 2) && rd_valid && $past(rd_valid))
      |-> (rd_data[6] != $past(rd_data[6])));
endmodule

bind fpe_engine fpe_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
);

// File: tb/fpe_engine_tb_top.sv
module fpe_engine_tb_top;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic boot_lock = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fpe_engine #(.ADDR_W(AW), .BLK_W(2), .BOOT_BLK(0), .PROG_CYC(4), .ERASE_CYC(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .boot_lock(boot_lock), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
  );

  // row: {read, op, addr, data/expected, requirement number}
  localparam int NV = 20;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 2'd0, 6'h05, 8'hFF, 6'd1},  // R1 erased after reset
    {1'b0, 2'd0, 6'h05, 8'hA5, 6'd2},
    {1'b1, 2'd0, 6'h05, 8'hA5, 6'd2},  // R2
    {1'b0, 2'd0, 6'h05, 8'h3C, 6'd2},
    {1'b1, 2'd0, 6'h05, 8'h24, 6'd2},  // R2 AND with old
    {1'b0, 2'd0, 6'h05, 8'hFF, 6'd2},
    {1'b1, 2'd0, 6'h05, 8'h24, 6'd2},  // R2 cannot set bits
    {1'b0, 2'd0, 6'h20, 8'h00, 6'd2},
    {1'b0, 2'd0, 6'h33, 8'h7E, 6'd2},
    {1'b1, 2'd0, 6'h20, 8'h00, 6'd2},
    {1'b0, 2'd1, 6'h20, 8'h00, 6'd3},
    {1'b1, 2'd0, 6'h20, 8'hFF, 6'd3},  // R3 block 2 erased
    {1'b1, 2'd0, 6'h33, 8'h7E, 6'd3},  // R3 block 3 kept
    {1'b1, 2'd0, 6'h05, 8'h24, 6'd3},  // R3 block 0 kept
    {1'b0, 2'd0, 6'h3F, 8'h11, 6'd2},
    {1'b1, 2'd0, 6'h3F, 8'h11, 6'd2},
    {1'b0, 2'd2, 6'h00, 8'h00, 6'd4},
    {1'b1, 2'd0, 6'h3F, 8'hFF, 6'd4},  // R4
    {1'b1, 2'd0, 6'h05, 8'hFF, 6'd4},
    {1'b1, 2'd0, 6'h33, 8'hFF, 6'd4}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
    chk("R7 ready before request", {7'd0, req_ready}, 8'd1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    step();
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = a;
    step();
    rd_en = 1'b0;
    v = rd_data;
    if (rd_valid !== 1'b1) chk("R11 rd_valid", {7'd0, rd_valid}, 8'd1);
  endtask

  task automatic idle();
    while (busy) step();
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin
      n++;
      step();
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 ready", {7'd0, req_ready}, 8'd1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][22]) begin
        rd(VEC[i][19:14], v);
        chk($sformatf("R%0d row %0d", VEC[i][5:0], i), v, VEC[i][13:6]);
      end else begin
        send(VEC[i][21:20], VEC[i][19:14], VEC[i][13:6]);
        idle();
      end
    end

    // R8 R9 R10: program 0x80 at 0x10, reads from first busy cycle
    send(2'd0, 6'h10, 8'h80);
    rd(6'h10, v); chk("R9 first status", v, 8'h40);
    rd(6'h10, v); chk("R9 second status", v, 8'h00);
    rd(6'h10, v); chk("R8 third status", v, 8'h40);
    chk("R6 busy before last cycle", {7'd0, busy}, 8'd1);
    rd(6'h10, v); chk("R10 read in completion cycle", v, 8'h80);
    chk("R6 busy dropped", {7'd0, busy}, 8'd0);

    send(2'd0, 6'h11, 8'h00);
    rd(6'h11, v); chk("R8 program bit7 inverted", v, 8'hC0);
    idle();

    send(2'd1, 6'h10, 8'h00);
    rd(6'h10, v); chk("R8 erase status", v, 8'h40);
    rd(6'h10, v); chk("R9 erase toggle", v, 8'h00);
    idle();
    rd(6'h10, v); chk("R8 erased reads FF", v, 8'hFF);

    // R6 busy lengths
    send(2'd0, 6'h12, 8'h55);
    count_busy(n); chk("R6 program length", 8'(n), 8'd4);
    send(2'd1, 6'h30, 8'h00);
    count_busy(n); chk("R6 erase length", 8'(n), 8'd6);

    // R7 request during chip erase dropped
    send(2'd2, 6'h00, 8'h00);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 6'h21; req_data = 8'h00;
    chk("R7 ready low while busy", {7'd0, req_ready}, 8'd0);
    step();
    req_valid = 1'b0;
    idle();
    rd(6'h21, v); chk("R7 dropped request", v, 8'hFF);

    // R12 no-op code
    send(2'd3, 6'h22, 8'h00);
    chk("R12 no busy", {7'd0, busy}, 8'd0);
    rd(6'h22, v); chk("R12 array unchanged", v, 8'hFF);

    // R5 boot block protection
    send(2'd0, 6'h02, 8'h00); idle();
    boot_lock = 1'b1;
    send(2'd0, 6'h03, 8'h00); idle();
    rd(6'h03, v); chk("R5 program blocked", v, 8'hFF);
    send(2'd0, 6'h30, 8'h00); idle();
    send(2'd2, 6'h00, 8'h00); idle();
    rd(6'h02, v); chk("R5 chip erase skips boot", v, 8'h00);
    rd(6'h30, v); chk("R5 chip erase other block", v, 8'hFF);
    send(2'd1, 6'h00, 8'h00); idle();
    rd(6'h02, v); chk("R5 block erase blocked", v, 8'h00);
    boot_lock = 1'b0;
    send(2'd1, 6'h00, 8'h00); idle();
    rd(6'h02, v); chk("R5 unlocked erase", v, 8'hFF);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule